// File: doc/BRIEF.md
# Multi-Link Bank-Switch Sync Controller

This block is a small memory-mapped control unit that sits beside up to four serial audio bus links. Software uses it to power links up and down, to set the period of a free-running sync pulse, and to switch register banks on several links at once. Each link has a power request that drives a power-enable line. Its power domain answers with an acknowledge after some delay, and only then does the link show itself as active.

The sync pulse comes from a down-counter. A period value written by software stays inactive until a self-clearing load bit moves it into the counter. For a coordinated bank switch, software sets one arm bit per participating link and then writes a single go bit. At the next sync boundary, every armed link that is powered receives a one-cycle strobe, all in the same clock cycle. The hardware then clears all arm bits and the go bit.

The design is built from three state machines. The per-link power machine has the states PWR_OFF, PWR_WAIT_ACK and PWR_ON:

- PWR_OFF moves to PWR_WAIT_ACK when the request is set.
- PWR_WAIT_ACK moves to PWR_ON when the acknowledge arrives, and back to PWR_OFF when the request drops.
- PWR_ON moves to PWR_OFF when the request drops.

The period machine has the states SYN_IDLE and SYN_COUNT:

- SYN_IDLE moves to SYN_COUNT when a nonzero period is loaded.
- SYN_COUNT returns to SYN_IDLE when a zero period is loaded.
- Inside SYN_COUNT, a zero count produces a pulse and reloads the counter.

The go machine has the states GO_IDLE and GO_ARMED:

- GO_IDLE moves to GO_ARMED when go is set and at least one arm bit is set.
- GO_IDLE drops go in place when go is set with no arm bit.
- GO_ARMED fires and returns to GO_IDLE at a boundary.

Top module: `mlink_sync_ctrl`

## Requirements
- R1: Offset 0x00 reads the configured link count in bits [2:0] and zero elsewhere. Any offset other than 0x00, 0x04 and 0x0C reads zero, and writes to such offsets change nothing.
- R2: At offset 0x04, bit n (n < link count) is the power request of link n. It drives pwr_en[n] from the cycle after the write. Bits at positions 4..7 that belong to no link are ignored and read zero.
- R3: Bit 8+n at offset 0x04 is read-only power status. It becomes 1 only while the request is set and after pwr_ack[n] has been seen high. Writes to it have no effect.
- R4: When a link's request is cleared, its status bit reads 0 no later than the second clock edge after the write.
- R5: Bits [14:0] at offset 0x0C hold a period that can be read back. Writing bit 15 as 1 sets a load flag. The load flag reads 1 until the period is applied one cycle later, and the hardware then clears it.
- R6: After a load of period P > 0, sync_pulse is high for one cycle every P+1 cycles. Before any load, and after a load of zero, no pulse occurs.
- R7: Bits 16+n at offset 0x0C are read/write arm bits, one for each link. Arm positions beyond the link count read zero.
- R8: Writing bit 24 (go) as 1 while arm bits are set has three effects. First, it produces a one-cycle bank_sw strobe on every armed, powered link, in the same cycle as a sync_pulse (or at once if the counter is idle). Second, it clears all arm bits. Third, it clears go.
- R9: Go written with no arm bit set produces no strobe, and go reads 0 again shortly afterwards.
- R10: An armed link whose status is 0 receives no strobe, but its arm bit is still cleared.
- R11: Bits [31:25] and [23:20] at offset 0x0C and bits [31:16] at offset 0x04 read zero whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) for reg_addr |
| pwr_ack | input | NUM_LINKS (4) | Power domain acknowledge per link |
| pwr_en | output | NUM_LINKS (4) | Power enable per link |
| sync_pulse | output | 1 | One-cycle sync pulse at each period boundary |
| bank_sw | output | NUM_LINKS (4) | One-cycle bank-switch strobe per link |

## Verification
The bound checker watches four kinds of behaviour on every cycle:

- No status bit rises without a prior acknowledge, and none survives a cleared request.
- The load flag never lingers after being applied.
- Every bank-switch strobe lasts a single cycle, coincides with a sync boundary and reaches only powered links.
- Go never falls while an arm bit is still set.

The actual period spacing, the register layout, the readback masks and the mapping from each arm pattern to a strobe pattern can be shown only by the bench's scenarios. The bench sweeps every period from 1 to 8 and all sixteen arm patterns against a fixed power pattern.

// File: rtl/mlsc_pkg.sv
package mlsc_pkg;
    localparam int MAX_LINKS = 4;

    localparam logic [7:0] ADR_CAP  = 8'h00;
    localparam logic [7:0] ADR_LINK = 8'h04;
    localparam logic [7:0] ADR_SYNC = 8'h0C;

    localparam int STAT_LSB    = 8;
    localparam int PRD_FIELD_W = 15;
    localparam int LOAD_POS    = 15;
    localparam int ARM_LSB     = 16;
    localparam int GO_POS      = 24;

    typedef enum logic [1:0] {
        PWR_OFF      = 2'd0,
        PWR_WAIT_ACK = 2'd1,
        PWR_ON       = 2'd2
    } pwr_state_e;

    typedef enum logic {
        SYN_IDLE  = 1'b0,
        SYN_COUNT = 1'b1
    } syn_state_e;

    typedef enum logic {
        GO_IDLE  = 1'b0,
        GO_ARMED = 1'b1
    } go_state_e;
endpackage

// File: rtl/mlsc_link_pwr.sv
module mlsc_link_pwr
    import mlsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic ack,
    output logic active
);
    pwr_state_e st_q;
    pwr_state_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PWR_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PWR_OFF: begin
                if (req) begin
                    st_d = PWR_WAIT_ACK;
                end
            end
            PWR_WAIT_ACK: begin
                if (!req) begin
                    st_d = PWR_OFF;
                end else if (ack) begin
                    st_d = PWR_ON;
                end
            end
            PWR_ON: begin
                if (!req) begin
                    st_d = PWR_OFF;
                end
            end
            default: st_d = PWR_OFF;
        endcase
    end

    always_comb begin
        active = (st_q == PWR_ON);
    end
endmodule

// File: rtl/mlsc_period_gen.sv
module mlsc_period_gen
    import mlsc_pkg::*;
#(
    parameter int PRD_W = PRD_FIELD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_req,
    input  logic [PRD_W-1:0] period_in,
    output logic             load_done,
    output logic             boundary,
    output logic             idle,
    output logic             sync_pulse
);
    syn_state_e       st_q;
    syn_state_e       st_d;
    logic [PRD_W-1:0] cnt_q;
    logic [PRD_W-1:0] cnt_d;
    logic [PRD_W-1:0] act_q;
    logic [PRD_W-1:0] act_d;
    logic             hit;
    logic             pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SYN_IDLE;
            cnt_q <= '0;
            act_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            act_q <= act_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        act_d = act_q;
        hit   = 1'b0;
        unique case (st_q)
            SYN_IDLE: begin
                if (load_req) begin
                    act_d = period_in;
                    cnt_d = period_in;
                    if (period_in != '0) begin
                        st_d = SYN_COUNT;
                    end
                end
            end
            SYN_COUNT: begin
                if (load_req) begin
                    act_d = period_in;
                    cnt_d = period_in;
                    st_d  = (period_in != '0) ? SYN_COUNT : SYN_IDLE;
                end else if (cnt_q == '0) begin
                    hit   = 1'b1;
                    cnt_d = act_q;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: st_d = SYN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= hit;
        end
    end

    always_comb begin
        load_done  = load_req;
        idle       = (st_q == SYN_IDLE);
        boundary   = idle || hit;
        sync_pulse = pulse_q;
    end
endmodule

// File: rtl/mlsc_go_fsm.sv
module mlsc_go_fsm
    import mlsc_pkg::*;
#(
    parameter int NUM_LINKS = MAX_LINKS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go_req,
    input  logic [NUM_LINKS-1:0] arm,
    input  logic [NUM_LINKS-1:0] link_on,
    input  logic                 boundary,
    output logic                 go_done,
    output logic                 arm_clr,
    output logic [NUM_LINKS-1:0] bank_sw
);
    go_state_e            st_q;
    go_state_e            st_d;
    logic                 fire;
    logic [NUM_LINKS-1:0] sw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= GO_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d    = st_q;
        go_done = 1'b0;
        fire    = 1'b0;
        unique case (st_q)
            GO_IDLE: begin
                if (go_req) begin
                    if (arm == '0) begin
                        go_done = 1'b1;
                    end else begin
                        st_d = GO_ARMED;
                    end
                end
            end
            GO_ARMED: begin
                if (boundary) begin
                    fire    = 1'b1;
                    go_done = 1'b1;
                    st_d    = GO_IDLE;
                end
            end
            default: st_d = GO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q <= '0;
        end else begin
            sw_q <= fire ? (arm & link_on) : '0;
        end
    end

    always_comb begin
        arm_clr = fire;
        bank_sw = sw_q;
    end
endmodule

// File: rtl/mlink_sync_ctrl.sv
module mlink_sync_ctrl
    import mlsc_pkg::*;
#(
    parameter int NUM_LINKS = MAX_LINKS,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_LINKS-1:0] pwr_ack,
    output logic [NUM_LINKS-1:0] pwr_en,
    output logic                 sync_pulse,
    output logic [NUM_LINKS-1:0] bank_sw
);
    localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(ADR_CAP);
    localparam logic [ADDR_W-1:0] A_LINK = ADDR_W'(ADR_LINK);
    localparam logic [ADDR_W-1:0] A_SYNC = ADDR_W'(ADR_SYNC);

    logic [NUM_LINKS-1:0]   req_q;
    logic [NUM_LINKS-1:0]   link_on;
    logic [NUM_LINKS-1:0]   arm_q;
    logic [PRD_FIELD_W-1:0] prd_q;
    logic                   load_q;
    logic                   go_q;
    logic                   wr_link;
    logic                   wr_sync;
    logic                   load_done;
    logic                   boundary;
    logic                   prd_idle;
    logic                   go_done;
    logic                   arm_clr;
    logic                   unused_wdata;

    assign wr_link      = reg_we && (reg_addr == A_LINK);
    assign wr_sync      = reg_we && (reg_addr == A_SYNC);
    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= '0;
            prd_q  <= '0;
            load_q <= 1'b0;
            arm_q  <= '0;
            go_q   <= 1'b0;
        end else begin
            if (wr_link) begin
                req_q <= reg_wdata[NUM_LINKS-1:0];
            end
            if (wr_sync) begin
                prd_q <= reg_wdata[PRD_FIELD_W-1:0];
            end
            load_q <= (load_q && !load_done) || (wr_sync && reg_wdata[LOAD_POS]);
            if (arm_clr) begin
                arm_q <= '0;
            end else if (wr_sync) begin
                arm_q <= reg_wdata[ARM_LSB +: NUM_LINKS];
            end
            go_q <= (go_q && !go_done) || (wr_sync && reg_wdata[GO_POS]);
        end
    end

    for (genvar n = 0; n < NUM_LINKS; n++) begin : g_link
        mlsc_link_pwr u_pwr (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (req_q[n]),
            .ack    (pwr_ack[n]),
            .active (link_on[n])
        );
    end

    mlsc_period_gen #(.PRD_W(PRD_FIELD_W)) u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_req   (load_q),
        .period_in  (prd_q),
        .load_done  (load_done),
        .boundary   (boundary),
        .idle       (prd_idle),
        .sync_pulse (sync_pulse)
    );

    mlsc_go_fsm #(.NUM_LINKS(NUM_LINKS)) u_go (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_req   (go_q),
        .arm      (arm_q),
        .link_on  (link_on),
        .boundary (boundary),
        .go_done  (go_done),
        .arm_clr  (arm_clr),
        .bank_sw  (bank_sw)
    );

    assign pwr_en = req_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CAP: begin
                reg_rdata[2:0] = 3'(NUM_LINKS);
            end
            A_LINK: begin
                reg_rdata[NUM_LINKS-1:0]          = req_q;
                reg_rdata[STAT_LSB +: NUM_LINKS]  = link_on;
            end
            A_SYNC: begin
                reg_rdata[PRD_FIELD_W-1:0]        = prd_q;
                reg_rdata[LOAD_POS]               = load_q;
                reg_rdata[ARM_LSB +: NUM_LINKS]   = arm_q;
                reg_rdata[GO_POS]                 = go_q;
            end
            default: begin
                reg_rdata = '0;
            end
        endcase
    end
endmodule

// File: rtl/mlink_sync_ctrl_chk.sv
module mlink_sync_ctrl_chk #(
    parameter int NUM_LINKS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_sync,
    input logic                 wr_load,
    input logic                 load_bit,
    input logic                 go_bit,
    input logic [NUM_LINKS-1:0] arm_bits,
    input logic [NUM_LINKS-1:0] link_on,
    input logic [NUM_LINKS-1:0] pwr_en,
    input logic [NUM_LINKS-1:0] pwr_ack,
    input logic [NUM_LINKS-1:0] bank_sw,
    input logic                 sync_pulse,
    input logic                 prd_idle
);
    // R3: a status bit rises only after the acknowledge was high
    p_status_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_on & ~$past(link_on) & ~$past(pwr_ack)) == '0));

    // R4: no status survives a request that was low at the previous edge
    p_status_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_on & ~$past(pwr_en)) == '0));

    // R5: the load flag clears once applied unless rewritten
    p_load_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_bit && !wr_load) |=> !load_bit);

    // R8: strobe lasts a single cycle
    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sw != '0) |=> (bank_sw == '0));

    // R8: strobe coincides with a sync boundary
    p_strobe_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sw != '0) |-> (sync_pulse || $past(prd_idle)));

    // R8: go only falls with every arm bit cleared
    p_go_clears_arms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(go_bit) && !$past(wr_sync)) |-> (arm_bits == '0));

    // R10: no strobe to a link that was not powered
    p_strobe_powered_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank_sw & ~$past(link_on)) == '0));
endmodule

bind mlink_sync_ctrl mlink_sync_ctrl_chk #(.NUM_LINKS(NUM_LINKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_sync    (wr_sync),
    .wr_load    (wr_sync && reg_wdata[15]),
    .load_bit   (load_q),
    .go_bit     (go_q),
    .arm_bits   (arm_q),
    .link_on    (link_on),
    .pwr_en     (pwr_en),
    .pwr_ack    (pwr_ack),
    .bank_sw    (bank_sw),
    .sync_pulse (sync_pulse),
    .prd_idle   (prd_idle)
);

// File: tb/mlink_sync_ctrl_tb.sv
module mlink_sync_ctrl_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [N-1:0] pwr_ack;
    logic [N-1:0] pwr_en;
    logic         sync_pulse;
    logic [N-1:0] bank_sw;

    logic [N-1:0] d0 = '0, d1 = '0, d2 = '0;
    logic [N-1:0] ack_block = 4'b1000;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    int last_pulse = -1;
    int interval = 0;
    int npulse = 0;
    int bsw_cnt = 0;
    logic [N-1:0] bsw_val = '0;
    logic bsw_pulse = 1'b0;

    always #5 clk = ~clk;

    mlink_sync_ctrl #(.NUM_LINKS(N), .ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_ack(pwr_ack),
        .pwr_en(pwr_en), .sync_pulse(sync_pulse), .bank_sw(bank_sw)
    );

    // power domain model: acknowledge follows enable after three cycles
    always @(posedge clk) begin
        d0 <= pwr_en;
        d1 <= d0;
        d2 <= d1;
    end
    assign pwr_ack = d2 & ~ack_block;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sync_pulse) begin
            if (last_pulse >= 0) interval = cyc - last_pulse;
            last_pulse = cyc;
            npulse = npulse + 1;
        end
        if (bank_sw != '0) begin
            bsw_cnt = bsw_cnt + 1;
            bsw_val = bank_sw;
            bsw_pulse = sync_pulse;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        @(negedge clk);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // reset state
        rd(8'h00, r); chk("R1 cap", r, 32'd4);
        rd(8'h04, r); chk("R2 reset link ctl", r, 32'h0);
        rd(8'h0C, r); chk("R6 reset sync", r, 32'h0);
        chk("R2 reset pwr_en", {28'h0, pwr_en}, 32'h0);
        chk("R8 reset bank_sw", {28'h0, bank_sw}, 32'h0);

        // R1: unmapped offsets read zero, writes to them ignored
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        for (int a = 0; a < 64; a += 4) begin
            if (a != 0 && a != 4 && a != 12) begin
                rd(8'(a), r); chk("R1 unmapped read", r, 32'h0);
            end
        end
        rd(8'h04, r); chk("R1 link ctl untouched", r, 32'h0);
        rd(8'h0C, r); chk("R1 sync untouched", r, 32'h0);

        // R2 / R11: request sweep with junk in status, unused and reserved bits
        for (int p = 0; p < 16; p++) begin
            wr(8'h04, 32'hFFFF_FFF0 | 32'(p));
            chk("R2 pwr_en", {28'h0, pwr_en}, 32'(p));
            rd(8'h04, r);
            chk("R2 request readback", r & 32'h0000_00FF, 32'(p));
            chk("R11 link ctl upper zero", r & 32'hFFFF_0000, 32'h0);
        end
        wr(8'h04, 32'h0);
        tick(8);
        rd(8'h04, r); chk("R4 all off", r, 32'h0);

        // R3: status only after acknowledge; link 3 never acknowledged
        wr(8'h04, 32'h0000_000F);
        rd(8'h04, r); chk("R3 no status before ack", r, 32'h0000_000F);
        tick(8);
        rd(8'h04, r); chk("R3 status after ack", r, 32'h0000_070F);

        // R3: status bits read-only
        wr(8'h04, 32'h0000_FF07);
        tick(1);
        rd(8'h04, r); chk("R3 status write ignored", r, 32'h0000_0707);

        // R4: dropping link 1
        wr(8'h04, 32'h0000_0005);
        tick(1);
        rd(8'h04, r); chk("R4 status cleared", r, 32'h0000_0505);
        wr(8'h04, 32'h0000_0007);
        tick(8);
        rd(8'h04, r); chk("R3 link 1 back", r, 32'h0000_0707);

        // R5 / R6: period without load has no effect
        wr(8'h0C, 32'h0000_0003);
        rd(8'h0C, r); chk("R5 period readback", r, 32'h0000_0003);
        npulse = 0;
        tick(20);
        chk("R6 no pulse before load", 32'(npulse), 32'h0);

        // R5 / R6: period sweep
        for (int p = 1; p <= 8; p++) begin
            wr(8'h0C, 32'h0000_8000 | 32'(p));
            if (p == 1) begin
                rd(8'h0C, r); chk("R5 load flag set", r, 32'h0000_8001);
                rd(8'h0C, r); chk("R5 load flag cleared", r, 32'h0000_0001);
            end
            tick(3 * (p + 1) + 4);
            chk("R6 pulse interval", 32'(interval), 32'(p + 1));
        end

        // R6: period zero stops pulses
        wr(8'h0C, 32'h0000_8000);
        tick(2);
        npulse = 0;
        tick(30);
        chk("R6 zero period idle", 32'(npulse), 32'h0);

        // R7 / R11: arm readback, reserved bits zero
        wr(8'h0C, 32'h0000_8003);
        tick(2);
        wr(8'h0C, 32'h00FF_0003);
        rd(8'h0C, r); chk("R7 arm readback", r, 32'h000F_0003);
        wr(8'h0C, 32'h0000_0003);

        // R8 / R9 / R10: all arm patterns, links 0..2 powered, link 3 not
        for (int a = 0; a < 16; a++) begin
            bsw_cnt = 0;
            wr(8'h0C, 32'h0100_0003 | (32'(a) << 16));
            tick(12);
            if ((a & 7) != 0) begin
                chk("R8 one strobe", 32'(bsw_cnt), 32'd1);
                chk("R10 strobe pattern", {28'h0, bsw_val}, 32'(a & 7));
                chk("R8 aligned with pulse", {31'h0, bsw_pulse}, 32'd1);
            end else begin
                chk("R9/R10 no strobe", 32'(bsw_cnt), 32'd0);
            end
            rd(8'h0C, r); chk("R8 arms and go cleared", r, 32'h0000_0003);
        end

        // R8: go with idle counter fires at once
        wr(8'h0C, 32'h0000_8000);
        tick(2);
        bsw_cnt = 0;
        wr(8'h0C, 32'h0101_0000);
        tick(4);
        chk("R8 idle fire count", 32'(bsw_cnt), 32'd1);
        chk("R8 idle fire pattern", {28'h0, bsw_val}, 32'd1);
        rd(8'h0C, r); chk("R8 idle cleared", r, 32'h0);

        // R11: reserved sync bits ignored
        wr(8'h0C, 32'hFEF0_0000);
        rd(8'h0C, r); chk("R11 sync reserved", r, 32'h0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule